// File: doc/BRIEF.md
# Triggered Serial State Readback Engine

This block streams the contents of an internal frame memory out of a single serial pin when a trigger asks for it. The frame holds two kinds of bits. Configuration bits come first and should never change while the device runs. State bits follow and change as the device operates. A host raises the trigger input to start a readback. It then collects one bit per rising edge of the readback clock. Comparing the configuration part against a golden copy shows whether the stored setup has been corrupted. The state part exposes internal values for probing.

The trigger is asynchronous. It passes through a synchronizer into the readback clock domain, and edges are detected on the synchronized value. A static option gates readback as a whole. A second static option lets a falling trigger edge cut a running stream short. A third static option picks the readback clock: either a user clock pin or the internal configuration clock. The frame memory has a word-wide write port in the readback clock domain. The surrounding capture logic uses that port to refresh the frame.

Top module: `rbk_stream_engine`

## Requirements
- R1: While reset is held and after it is released, `rb_dout`, `rb_busy` and `rb_kind` are 0 until a readback starts.
- R2: With `opt_rb_en` set, a 0-to-1 change of `trig` ahead of a readback clock edge is seen on the third rising edge. On that edge `rb_busy` goes to 1 and `rb_dout` carries frame bit 0.
- R3: One frame is N = 2^(WORD_LG+DEPTH_LG) bits, one bit per rising edge. Memory words go out in ascending address order, and each word goes out least significant bit first, so frame bit i is bit (i mod 2^WORD_LG) of word (i div 2^WORD_LG).
- R4: `rb_busy` stays 1 for exactly N clocks. It falls, and `rb_dout` returns to 0, on the edge after the last bit.
- R5: `rb_kind` is 0 for frame bits below CFG_BITS (configuration) and 1 for the rest (state). It is 0 whenever `rb_busy` is 0.
- R6: With `opt_rb_en` clear, rising edges of `trig` are ignored and `rb_busy` stays 0.
- R7: A rising edge of `trig` while `rb_busy` is 1 neither restarts nor lengthens the frame, and no new frame follows it.
- R8: With `opt_abort_en` set, a 1-to-0 change of `trig` during a frame is seen on the third rising edge. On that edge `rb_busy` and `rb_dout` go to 0, and the bits due on the two edges before it still go out normally.
- R9: With `opt_abort_en` clear, a falling `trig` during a frame has no effect, and all N bits are delivered.
- R10: `opt_clk_sel` = 0 clocks the engine from `clk_user`; `opt_clk_sel` = 1 clocks it from `clk_cfg`. The unselected clock has no effect.
- R11: A word written through `wr_en`/`wr_addr`/`wr_data` while idle appears at its position in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_user | input | 1 | User-supplied readback clock |
| clk_cfg | input | 1 | Internal configuration clock |
| rst | input | 1 | Synchronous active-high reset, in the selected clock domain |
| opt_rb_en | input | 1 | Static option: readback allowed |
| opt_abort_en | input | 1 | Static option: falling trigger aborts a frame |
| opt_clk_sel | input | 1 | Static option: 0 = user clock, 1 = configuration clock |
| trig | input | 1 | Asynchronous readback trigger |
| wr_en | input | 1 | Frame memory write strobe |
| wr_addr | input | DEPTH_LG | Frame memory word address |
| wr_data | input | 2^WORD_LG | Frame memory word |
| rb_dout | output | 1 | Serial readback data |
| rb_busy | output | 1 | Readback in progress |
| rb_kind | output | 1 | Current bit is a state bit (1) or a configuration bit (0) |

## Verification
The assertions follow every clock. They check that the output stays quiet while idle, and that the kind flag matches a bit counter kept in the checker. They also check that a frame never runs past N bits and ends exactly after N, that a frame starts only when readback is enabled, and that a frame ends early only when abort is enabled. Only the bench scenarios can show the actual bit values and their order against a memory model. The same goes for the synchronizer latency of start and abort, the ignored re-trigger, the disabled-enable case, and which clock pin actually drives the engine.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

  // Edge events produced by the trigger synchronizer.
  typedef struct packed {
    logic rise;
    logic fall;
  } trig_evt_t;

  // Sequencer phase.
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_SHIFT = 1'b1
  } rb_phase_t;

endpackage

// File: rtl/rbk_clk_sel.sv
module rbk_clk_sel (
  input  logic clk_user,
  input  logic clk_cfg,
  input  logic sel_cfg,
  output logic clk_out
);

  // Static selection; the select only changes while both clocks are quiet.
  assign clk_out = sel_cfg ? clk_cfg : clk_user;

endmodule

// File: rtl/rbk_trig_sync.sv
module rbk_trig_sync
  import rbk_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      trig_async,
  output trig_evt_t evt
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= trig_async;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign evt.rise = chain[STAGES-1] & ~last_q;
  assign evt.fall = ~chain[STAGES-1] & last_q;

endmodule

// File: rtl/rbk_frame_mem.sv
module rbk_frame_mem #(
  parameter int WORD_LG  = 3,
  parameter int DEPTH_LG = 2
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [DEPTH_LG-1:0]   waddr,
  input  logic [2**WORD_LG-1:0] wdata,
  input  logic [DEPTH_LG-1:0]   raddr,
  output logic [2**WORD_LG-1:0] rdata
);

  localparam int W     = 2**WORD_LG;
  localparam int DEPTH = 2**DEPTH_LG;

  logic [W-1:0] store [DEPTH];

  // Single write port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/rbk_sequencer.sv
module rbk_sequencer
  import rbk_pkg::*;
#(
  parameter int WORD_LG  = 3,
  parameter int DEPTH_LG = 2,
  parameter int CFG_BITS = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  abort,
  input  logic [2**WORD_LG-1:0] word_in,
  output logic [DEPTH_LG-1:0]   word_addr,
  output logic                  dout,
  output logic                  busy,
  output logic                  kind
);

  localparam int W  = 2**WORD_LG;
  localparam int CW = WORD_LG + DEPTH_LG;
  localparam int N  = 2**CW;
  localparam logic [CW:0] LAST_CNT = (CW+1)'(N);
  localparam logic [CW:0] CFG_LIM  = (CW+1)'(CFG_BITS);

  rb_phase_t     phase;
  logic [CW:0]   nxt;      // index of the next bit to send
  logic [W-1:0]  shreg;
  logic          at_word;  // next bit opens a fresh word

  assign at_word = (nxt[WORD_LG-1:0] == '0);

  // Look one word ahead so the registered read is ready on the word boundary.
  always_comb begin
    if (phase == PH_SHIFT) word_addr = nxt[CW-1:WORD_LG] + DEPTH_LG'(1);
    else                   word_addr = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      nxt   <= '0;
      shreg <= '0;
      dout  <= 1'b0;
      kind  <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_SHIFT;
        dout  <= word_in[0];
        shreg <= word_in >> 1;
        kind  <= (CFG_BITS == 0);
        nxt   <= (CW+1)'(1);
      end
    end else if (abort || nxt == LAST_CNT) begin
      phase <= PH_IDLE;
      nxt   <= '0;
      dout  <= 1'b0;
      kind  <= 1'b0;
    end else begin
      if (at_word) begin
        dout  <= word_in[0];
        shreg <= word_in >> 1;
      end else begin
        dout  <= shreg[0];
        shreg <= shreg >> 1;
      end
      kind <= (nxt >= CFG_LIM);
      nxt  <= nxt + (CW+1)'(1);
    end
  end

  assign busy = (phase == PH_SHIFT);

endmodule

// File: rtl/rbk_stream_engine.sv
module rbk_stream_engine
  import rbk_pkg::*;
#(
  parameter int WORD_LG     = 3,
  parameter int DEPTH_LG    = 2,
  parameter int CFG_BITS    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_user,
  input  logic                  clk_cfg,
  input  logic                  rst,
  input  logic                  opt_rb_en,
  input  logic                  opt_abort_en,
  input  logic                  opt_clk_sel,
  input  logic                  trig,
  input  logic                  wr_en,
  input  logic [DEPTH_LG-1:0]   wr_addr,
  input  logic [2**WORD_LG-1:0] wr_data,
  output logic                  rb_dout,
  output logic                  rb_busy,
  output logic                  rb_kind
);

  localparam int W = 2**WORD_LG;

  logic                rb_clk;
  trig_evt_t           evt;
  logic [DEPTH_LG-1:0] rd_addr;
  logic [W-1:0]        rd_word;
  logic                go;
  logic                stop;

  rbk_clk_sel u_clk (
    .clk_user (clk_user),
    .clk_cfg  (clk_cfg),
    .sel_cfg  (opt_clk_sel),
    .clk_out  (rb_clk)
  );

  rbk_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (rb_clk),
    .rst        (rst),
    .trig_async (trig),
    .evt        (evt)
  );

  assign go   = evt.rise & opt_rb_en;
  assign stop = evt.fall & opt_abort_en;

  rbk_frame_mem #(.WORD_LG(WORD_LG), .DEPTH_LG(DEPTH_LG)) u_mem (
    .clk   (rb_clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  rbk_sequencer #(
    .WORD_LG  (WORD_LG),
    .DEPTH_LG (DEPTH_LG),
    .CFG_BITS (CFG_BITS)
  ) u_seq (
    .clk       (rb_clk),
    .rst       (rst),
    .start     (go),
    .abort     (stop),
    .word_in   (rd_word),
    .word_addr (rd_addr),
    .dout      (rb_dout),
    .busy      (rb_busy),
    .kind      (rb_kind)
  );

endmodule

// File: rtl/rbk_checker.sv
module rbk_checker #(
  parameter int WORD_LG  = 3,
  parameter int DEPTH_LG = 2,
  parameter int CFG_BITS = 20
) (
  input logic clk,
  input logic rst,
  input logic opt_rb_en,
  input logic opt_abort_en,
  input logic rb_dout,
  input logic rb_busy,
  input logic rb_kind
);

  localparam int CW = WORD_LG + DEPTH_LG;
  localparam int N  = 2**CW;
  localparam logic [CW:0] N_C   = (CW+1)'(N);
  localparam logic [CW:0] N1_C  = (CW+1)'(N - 1);
  localparam logic [CW:0] CFG_C = (CW+1)'(CFG_BITS);

  // Independent count of cycles spent busy.
  logic [CW:0] seen;
  always_ff @(posedge clk) begin
    if (rst)          seen <= '0;
    else if (rb_busy) seen <= seen + (CW+1)'(1);
    else              seen <= '0;
  end

  // R4: idle output is quiet
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !rb_busy |-> !rb_dout);

  // R4: a full frame ends right after N busy cycles
  p_frame_end_r4: assert property (@(posedge clk) disable iff (rst)
    (rb_busy && seen == N1_C) |=> !rb_busy);

  // R3: never more than N bits in one frame
  p_no_overrun_r3: assert property (@(posedge clk) disable iff (rst)
    rb_busy |-> (seen < N_C));

  // R5: kind flag follows the bit position
  p_kind_map_r5: assert property (@(posedge clk) disable iff (rst)
    rb_busy |-> (rb_kind == (seen >= CFG_C)));

  // R5: kind flag low while idle
  p_kind_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !rb_busy |-> !rb_kind);

  // R6: a frame only starts when readback is enabled
  p_start_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_busy) |-> $past(opt_rb_en));

  // R8: a short frame implies abort was enabled
  p_abort_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rb_busy) |-> (seen == N_C || $past(opt_abort_en)));

endmodule

bind rbk_stream_engine rbk_checker #(
  .WORD_LG  (WORD_LG),
  .DEPTH_LG (DEPTH_LG),
  .CFG_BITS (CFG_BITS)
) u_chk (
  .clk          (rb_clk),
  .rst          (rst),
  .opt_rb_en    (opt_rb_en),
  .opt_abort_en (opt_abort_en),
  .rb_dout      (rb_dout),
  .rb_busy      (rb_busy),
  .rb_kind      (rb_kind)
);

// File: tb/sim_rbk_stream_engine.sv
module sim_rbk_stream_engine;

  localparam time PERIOD   = 10ns;
  localparam int  WORD_LG  = 3;
  localparam int  DEPTH_LG = 2;
  localparam int  CFG_BITS = 20;
  localparam int  W        = 2**WORD_LG;
  localparam int  DEPTH    = 2**DEPTH_LG;
  localparam int  N        = W * DEPTH;

  logic tck = 1'b0;
  logic run_user = 1'b1;
  logic run_cfg  = 1'b0;
  logic clk_user, clk_cfg;
  logic rst = 1'b1;
  logic opt_rb_en = 1'b1, opt_abort_en = 1'b0, opt_clk_sel = 1'b0;
  logic trig = 1'b0;
  logic wr_en = 1'b0;
  logic [DEPTH_LG-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic rb_dout, rb_busy, rb_kind;

  logic [W-1:0] model [DEPTH];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) tck = ~tck;
  assign clk_user = tck & run_user;
  assign clk_cfg  = tck & run_cfg;

  rbk_stream_engine #(
    .WORD_LG(WORD_LG), .DEPTH_LG(DEPTH_LG), .CFG_BITS(CFG_BITS), .SYNC_STAGES(2)
  ) u0 (
    .clk_user(clk_user), .clk_cfg(clk_cfg), .rst(rst),
    .opt_rb_en(opt_rb_en), .opt_abort_en(opt_abort_en), .opt_clk_sel(opt_clk_sel),
    .trig(trig), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rb_dout(rb_dout), .rb_busy(rb_busy), .rb_kind(rb_kind)
  );

  task automatic step();
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int i);
    return model[i / W][i % W];
  endfunction

  task automatic put_word(input int a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = DEPTH_LG'(a); wr_data = d;
    step();
    wr_en = 1'b0;
    model[a] = d;
  endtask

  // One triggered frame. drop_at / rerise_at: bit index after which trig
  // falls / rises again (-1 for never). cut: an abort is expected.
  task automatic frame(input int drop_at, input int rerise_at, input bit cut, input string tag);
    bit ended = 1'b0;
    trig = 1'b1;
    step(); chk(32'(rb_busy), 0, {tag, " R2 no start after 1 edge"});
    step(); chk(32'(rb_busy), 0, {tag, " R2 no start after 2 edges"});
    step();
    for (int i = 0; i < N; i++) begin
      if (cut && i == drop_at + 3) begin
        chk(32'(rb_busy), 0, $sformatf("%s R8 busy cleared at bit %0d", tag, i));
        chk(32'(rb_dout), 0, $sformatf("%s R8 dout cleared at bit %0d", tag, i));
        ended = 1'b1;
        break;
      end
      chk(32'(rb_busy), 1, $sformatf("%s R2 busy at bit %0d", tag, i));
      chk(32'(rb_dout), 32'(exp_bit(i)), $sformatf("%s R3 data bit %0d", tag, i));
      chk(32'(rb_kind), 32'(i >= CFG_BITS), $sformatf("%s R5 kind bit %0d", tag, i));
      if (i == drop_at)   trig = 1'b0;
      if (i == rerise_at) trig = 1'b1;
      step();
    end
    if (!ended) begin
      chk(32'(rb_busy), 0, {tag, " R4 busy falls after last bit"});
      chk(32'(rb_dout), 0, {tag, " R4 dout low after last bit"});
      chk(32'(rb_kind), 0, {tag, " R5 kind low when idle"});
      for (int k = 0; k < 4; k++) begin
        step();
        chk(32'(rb_busy), 0, {tag, " R7 no restart"});
      end
    end
    trig = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk(32'(rb_busy), 0, {tag, " R1 idle between frames"});
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge tck);
    step(); step(); step();
    chk(32'(rb_busy), 0, "R1 busy in reset");
    chk(32'(rb_dout), 0, "R1 dout in reset");
    rst = 1'b0;
    step();
    chk(32'(rb_busy), 0, "R1 busy after reset");
    chk(32'(rb_dout), 0, "R1 dout after reset");
    chk(32'(rb_kind), 0, "R1 kind after reset");

    // Pattern sweep, full frames.
    for (int p = 0; p < 3; p++) begin
      for (int w = 0; w < DEPTH; w++)
        put_word(w, W'((w * 59 + p * 83 + 8'h5A) ^ (p * 8'h33)));
      frame(-1, -1, 1'b0, $sformatf("pat%0d", p));
    end

    // R9 and R7: abort disabled, trigger drops then rises mid-frame.
    opt_abort_en = 1'b0;
    frame(9, 17, 1'b0, "R9_R7 drop+rerise");

    // Abort enabled but trigger held: full frame still.
    opt_abort_en = 1'b1;
    frame(-1, -1, 1'b0, "R8 held trig");
    // R8: aborts at several points including just before the end.
    frame(0, -1, 1'b1, "R8 early");
    frame(13, -1, 1'b1, "R8 mid");
    frame(N - 4, -1, 1'b1, "R8 late");
    opt_abort_en = 1'b0;

    // R11: rewrite one word, next frame shows it.
    put_word(2, 8'hC3);
    put_word(0, 8'h01);
    frame(-1, -1, 1'b0, "R11 rewrite");

    // R6: readback disabled.
    opt_rb_en = 1'b0;
    trig = 1'b1;
    for (int k = 0; k < N + 6; k++) begin
      step();
      chk(32'(rb_busy), 0, $sformatf("R6 disabled cycle %0d", k));
    end
    trig = 1'b0;
    repeat (4) step();
    opt_rb_en = 1'b1;

    // R10: select the configuration clock while only the user clock runs.
    opt_clk_sel = 1'b1;
    trig = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step();
      chk(32'(rb_busy), 0, $sformatf("R10 user clock unselected cycle %0d", k));
    end
    trig = 1'b0;
    run_cfg = 1'b1; run_user = 1'b0;
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    frame(-1, -1, 1'b0, "R10 cfg clock");

    // Back to the user clock.
    opt_clk_sel = 1'b0;
    run_user = 1'b1; run_cfg = 1'b0;
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    put_word(3, 8'hE7);
    frame(-1, -1, 1'b0, "R10 user clock");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule